// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block derives the serial clock for an I2C master from a fast parent clock. A prescaler divides the parent clock into ticks. A pair of nested counters groups those ticks into half periods: a step counter runs inside a sample counter. Each half of the SCL period therefore lasts divider × sample count × step count parent cycles, and the bus rate is the parent clock over twice that product.

The transaction sequencer turns the generator on with `enable`. It then receives the SCL level, a shift strobe in the middle of every low half and a sample strobe in the middle of every high half. Two timing words are held: one for standard/fast mode and one for high-speed mode. Once the sequencer has sent the master code it raises `hs_req`, and from the next half-period boundary the high-speed word governs the timing. A start-hold option keeps SCL high for one or two half periods before the first low phase, so the start condition can be held longer at the slowest bus rates.

Top module: `i2c_scl_timegen`

## Requirements
- R1: While the generator runs, a prescaled tick occurs every `clkdiv_m1`+1 parent clocks, and every half period is a whole number of these ticks.
- R2: With standard timing, every low and every high half of SCL lasts S × T × D parent clocks, where D = `clkdiv_m1`+1, S is the sample count and T is the step count. SCL changes level only on a tick.
- R3: `std_timing` carries S−1 in bits [10:8] (S from 1 to 8) and T−1 in bits [5:0] (T from 1 to 64). All other bits are ignored.
- R4: Exactly one `shift_stb` pulse occurs in each low half, and none in a high half. It appears ((S/2 rounded down) × T + 1) × D − 1 clocks after SCL has fallen.
- R5: Exactly one `sample_stb` pulse occurs in each high half, and none in a low half. It uses the same offset from the SCL rise as R4.
- R6: One clock after `enable` is seen low, SCL is high (released). No strobes occur while `enable` stays low.
- R7: After `enable` rises, SCL stays high for one half period when `hold_long`=0, or two half periods when `hold_long`=1, before the first low half. `hold_long` is sampled on the cycle in which `enable` is first seen.
- R8: A one-cycle `hs_req` while running, with `hs_timing[1:0]`=2'b11, sets `hs_active` on the next clock. Every half period that starts after that uses S−1 from `hs_timing[14:12]` and T−1 from `hs_timing[10:8]`, so T is at most 8.
- R9: An `hs_req` while `hs_timing[1:0]` is not 2'b11 is ignored. `hs_active` stays low and the halves keep the standard length.
- R10: Dropping `enable` clears `hs_active`. The next run starts in standard timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request from the sequencer; low returns SCL to released |
| hold_long | input | 1 | Start hold of two half periods instead of one |
| clkdiv_m1 | input | DIV_W | Prescale divider minus one |
| std_timing | input | 16 | Standard/fast timing word (R3) |
| hs_timing | input | 16 | High-speed timing word (R8) |
| hs_req | input | 1 | Pulse: master code sent, switch to high-speed timing |
| scl_o | output | 1 | SCL level, 1 = released/high |
| shift_stb | output | 1 | Mid-low strobe for driving the next data bit |
| sample_stb | output | 1 | Mid-high strobe for sampling SDA |
| hs_active | output | 1 | High-speed timing selected |

## Verification
The bench builds the block with the default divider width of 8 bits. It programs dividers of 1, 2, 4 and 5. These cover a tick on every cycle, where the strobe lands in the same cycle as the SCL edge. They also cover the largest standard counts (8 × 64), which give 512-cycle halves, and odd sample counts, where the midpoint rounds down. The high-speed word is switched in partway through a run, and it is checked both with and without its enable code.

// File: rtl/i2c_tg_pkg.sv
package i2c_tg_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_START, PH_LOW, PH_HIGH} phase_e;

  localparam int SAMP_W     = 3;
  localparam int STEP_W     = 6;
  localparam int HS_STEP_W  = 3;
  localparam int CFG_W      = 16;
  localparam int STD_SAMP_LSB = 8;
  localparam int STD_STEP_LSB = 0;
  localparam int HS_SAMP_LSB  = 12;
  localparam int HS_STEP_LSB  = 8;
  localparam logic [1:0] HS_EN_CODE = 2'b11;
endpackage

// File: rtl/tg_prescaler.sv
module tg_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_m1,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt >= div_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  // a divider above one never yields two ticks in a row
  p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_m1 != '0 && $stable(div_m1)) |=> !tick);
endmodule

// File: rtl/tg_half_counter.sv
module tg_half_counter #(
  parameter int SAMP_W = 3,
  parameter int STEP_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  logic [SAMP_W-1:0] samp_m1,
  input  logic [STEP_W-1:0] step_m1,
  output logic              half_done,
  output logic              at_mid
);
  logic [SAMP_W-1:0] samp_cnt;
  logic [STEP_W-1:0] step_cnt;
  logic [SAMP_W:0]   mid_samp;
  logic              step_wrap;

  assign mid_samp  = ({1'b0, samp_m1} + 1'b1) >> 1;
  assign step_wrap = (step_cnt == step_m1);
  assign half_done = tick && step_wrap && (samp_cnt == samp_m1);
  assign at_mid    = tick && (step_cnt == '0) && ({1'b0, samp_cnt} == mid_samp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_cnt <= '0;
      step_cnt <= '0;
    end else if (!run) begin
      samp_cnt <= '0;
      step_cnt <= '0;
    end else if (tick) begin
      if (step_wrap) begin
        step_cnt <= '0;
        samp_cnt <= (samp_cnt == samp_m1) ? '0 : samp_cnt + 1'b1;
      end else begin
        step_cnt <= step_cnt + 1'b1;
      end
    end
  end

  // counters never run past the limits latched for the current half
  p_step_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (step_cnt <= step_m1 && samp_cnt <= samp_m1));
endmodule

// File: rtl/i2c_scl_timegen.sv
module i2c_scl_timegen
  import i2c_tg_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             hold_long,
  input  logic [DIV_W-1:0] clkdiv_m1,
  input  logic [15:0]      std_timing,
  input  logic [15:0]      hs_timing,
  input  logic             hs_req,
  output logic             scl_o,
  output logic             shift_stb,
  output logic             sample_stb,
  output logic             hs_active
);
  localparam int HS_PAD = STEP_W - HS_STEP_W;

  phase_e            phase;
  logic              hold_left;
  logic              running;
  logic              tick;
  logic              half_done;
  logic              at_mid;
  logic [SAMP_W-1:0] cur_samp_m1, sel_samp_m1;
  logic [STEP_W-1:0] cur_step_m1, sel_step_m1;
  logic [SAMP_W-1:0] std_samp, hs_samp;
  logic [STEP_W-1:0] std_step, hs_step;
  logic              hs_accept;

  assign running  = (phase != PH_IDLE);
  assign std_samp = std_timing[STD_SAMP_LSB +: SAMP_W];
  assign std_step = std_timing[STD_STEP_LSB +: STEP_W];
  assign hs_samp  = hs_timing[HS_SAMP_LSB +: SAMP_W];
  assign hs_step  = {{HS_PAD{1'b0}}, hs_timing[HS_STEP_LSB +: HS_STEP_W]};
  assign sel_samp_m1 = hs_active ? hs_samp : std_samp;
  assign sel_step_m1 = hs_active ? hs_step : std_step;
  assign hs_accept = running && enable && hs_req && (hs_timing[1:0] == HS_EN_CODE);

  tg_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(running), .div_m1(clkdiv_m1), .tick(tick)
  );

  tg_half_counter #(.SAMP_W(SAMP_W), .STEP_W(STEP_W)) u_half (
    .clk(clk), .rst_n(rst_n), .run(running), .tick(tick),
    .samp_m1(cur_samp_m1), .step_m1(cur_step_m1),
    .half_done(half_done), .at_mid(at_mid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= PH_IDLE;
      hold_left   <= 1'b0;
      cur_samp_m1 <= '0;
      cur_step_m1 <= '0;
      hs_active   <= 1'b0;
    end else if (!running) begin
      cur_samp_m1 <= std_samp;
      cur_step_m1 <= std_step;
      hs_active   <= 1'b0;
      if (enable) begin
        phase     <= PH_START;
        hold_left <= hold_long;
      end
    end else if (!enable) begin
      phase     <= PH_IDLE;
      hs_active <= 1'b0;
    end else begin
      if (hs_accept) hs_active <= 1'b1;
      if (half_done) begin
        cur_samp_m1 <= sel_samp_m1;
        cur_step_m1 <= sel_step_m1;
        case (phase)
          PH_START: begin
            if (hold_left) hold_left <= 1'b0;
            else           phase     <= PH_LOW;
          end
          PH_LOW:  phase <= PH_HIGH;
          default: phase <= PH_LOW;
        endcase
      end
    end
  end

  assign scl_o      = (phase != PH_LOW);
  assign shift_stb  = (phase == PH_LOW)  && at_mid;
  assign sample_stb = (phase == PH_HIGH) && at_mid;

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!enable) |-> (scl_o && !shift_stb && !sample_stb));

  p_scl_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(scl_o) && $past(enable)) |-> $past(tick));

  p_hs_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_active) |-> ($past(hs_req) && $past(hs_timing[1:0]) == HS_EN_CODE));

  p_hs_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!enable) |-> !hs_active);
endmodule

// File: tb/test_i2c_scl_timegen.sv
module test_i2c_scl_timegen;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, hold_long = 1'b0, hs_req = 1'b0;
  logic [DIV_W-1:0] clkdiv_m1 = 8'd3;
  logic [15:0] std_timing = '0, hs_timing = '0;
  logic scl_o, shift_stb, sample_stb, hs_active;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_scl_timegen #(.DIV_W(DIV_W)) i_i2c_scl_timegen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .hold_long(hold_long),
    .clkdiv_m1(clkdiv_m1), .std_timing(std_timing), .hs_timing(hs_timing),
    .hs_req(hs_req), .scl_o(scl_o), .shift_stb(shift_stb),
    .sample_stb(sample_stb), .hs_active(hs_active)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] std_word(int s, int t);
    return 16'(((s - 1) << 8) | (t - 1));
  endfunction

  function automatic logic [15:0] hs_word(int s, int t, bit en);
    return 16'(((s - 1) << 12) | ((t - 1) << 8) | (en ? 3 : 0));
  endfunction

  function automatic int mid_off(int d, int s, int t);
    return ((s / 2) * t + 1) * d - 1;
  endfunction

  // called at the first negedge of a half; returns at the first negedge of the next
  task automatic measure_half(output int len, output int off, output int nsh, output int nsa);
    logic v;
    int idx;
    v = scl_o; idx = 0; off = -1; nsh = 0; nsa = 0;
    forever begin
      if (shift_stb)  begin nsh++; if (off < 0) off = idx; end
      if (sample_stb) begin nsa++; if (off < 0) off = idx; end
      @(negedge clk);
      idx++;
      if (scl_o != v || idx > 5000) break;
    end
    len = idx;
  endtask

  task automatic wait_scl(logic v);
    int n = 0;
    while (scl_o !== v && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic stop_run();
    enable = 1'b0;
    @(negedge clk);
  endtask

  task automatic test_reset();
    chk("R6 reset scl", int'(scl_o), 1);
    chk("R6 reset strobes", int'(shift_stb | sample_stb), 0);
    chk("R10 reset hs_active", int'(hs_active), 0);
  endtask

  task automatic test_std(string tag, int d, int s, int t);
    int len, off, nsh, nsa;
    clkdiv_m1 = DIV_W'(d - 1);
    std_timing = std_word(s, t) | 16'hF8C0; // unused bits set: R3 ignores them
    hold_long = 1'b0;
    enable = 1'b1;
    wait_scl(1'b0);
    measure_half(len, off, nsh, nsa);
    chk({tag, " R1 R2 R3 low len"}, len, s * t * d);
    chk({tag, " R4 shift offset"}, off, mid_off(d, s, t));
    chk({tag, " R4 strobe counts"}, nsh * 10 + nsa, 10);
    measure_half(len, off, nsh, nsa);
    chk({tag, " R2 high len"}, len, s * t * d);
    chk({tag, " R5 sample offset"}, off, mid_off(d, s, t));
    chk({tag, " R5 strobe counts"}, nsh * 10 + nsa, 1);
    stop_run();
  endtask

  task automatic test_idle();
    int seen = 0;
    clkdiv_m1 = 8'd0; std_timing = std_word(1, 2);
    enable = 1'b1;
    wait_scl(1'b0);
    stop_run();
    chk("R6 scl released after disable", int'(scl_o), 1);
    for (int i = 0; i < 30; i++) begin
      if (!scl_o || shift_stb || sample_stb) seen++;
      @(negedge clk);
    end
    chk("R6 quiet while disabled", seen, 0);
  endtask

  task automatic test_start_hold(bit h);
    int n = 0;
    clkdiv_m1 = 8'd1; std_timing = std_word(2, 2);
    hold_long = h;
    enable = 1'b1;
    while (scl_o && n < 5000) begin @(negedge clk); n++; end
    chk(h ? "R7 long start hold" : "R7 short start hold", n, (h + 1) * 8 + 1);
    stop_run();
  endtask

  task automatic test_hs(bit code_ok);
    int len, off, nsh, nsa;
    clkdiv_m1 = 8'd1; std_timing = std_word(2, 4);
    hs_timing = hs_word(2, 3, code_ok);
    hold_long = 1'b0;
    enable = 1'b1;
    wait_scl(1'b0);
    hs_req = 1'b1;
    @(negedge clk);
    hs_req = 1'b0;
    if (code_ok) chk("R8 hs_active set", int'(hs_active), 1);
    else         chk("R9 hs_req ignored", int'(hs_active), 0);
    wait_scl(1'b1);
    measure_half(len, off, nsh, nsa);
    if (code_ok) begin
      chk("R8 hs high len", len, 12);
      chk("R8 hs sample offset", off, mid_off(2, 2, 3));
      measure_half(len, off, nsh, nsa);
      chk("R8 hs low len", len, 12);
      stop_run();
      chk("R10 hs cleared on disable", int'(hs_active), 0);
      enable = 1'b1;
      wait_scl(1'b0);
      measure_half(len, off, nsh, nsa);
      chk("R10 std timing on restart", len, 16);
    end else begin
      chk("R9 std high len kept", len, 16);
    end
    stop_run();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_std("D4S2T3", 4, 2, 3);
    test_std("D1S1T1", 1, 1, 1);
    test_std("D5S3T5", 5, 3, 5);
    test_std("D1S8T64", 1, 8, 64);
    test_idle();
    test_start_hold(1'b0);
    test_start_hold(1'b1);
    test_hs(1'b1);
    test_hs(1'b0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule